// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit linear address into a physical address after a translation miss. It reads two 4-byte entries from memory in turn: first a directory entry, which it finds from the directory frame register and the top ten address bits, and then a table entry, which it finds from the directory entry's frame and the next ten bits. It checks the present and permission flags at both levels. It sets the accessed and dirty flags in memory by writing the entry back. It then returns either the physical address or a fault code.

The caller gives a virtual address, a write flag and a user flag for one cycle while the walker is idle. The walker raises `busy` until it gives a one-cycle response. Memory traffic goes through a single request/acknowledge port. The walker keeps a request and its address and data steady until the acknowledge arrives, and it reads `mem_rdata` in the acknowledge cycle.

Top module: `ptw_walker`

## Requirements
- R1: The directory entry address is `{dir_frame, va[31:22], 2'b00}`, so it is the directory frame plus four times the directory index.
- R2: The table entry address is `{dir_entry[31:12], va[21:12], 2'b00}`.
- R3: A successful walk returns `rsp_fault = 0` and `rsp_paddr = {table_entry[31:12], va[11:0]}`.
- R4: If bit 0 (present) of the directory entry is clear, the walk ends with `rsp_fault = 1` after that one read. Nothing is written and `rsp_paddr` is zero.
- R5: If bit 0 of the table entry is clear, the walk ends with `rsp_fault = 1`. The table entry is not written.
- R6: A write needs bit 1 (writable) set at both levels. A user access needs bit 2 (user) set at both levels. A denied access ends with `rsp_fault = 2` at the first level that denies it. The denying entry is not written, and a directory-level denial issues no table read.
- R7: An entry used by a walk that passes its own checks gets bit 5 (accessed) set by a write-back. All other bits of the entry are left unchanged.
- R8: A write walk also sets bit 6 (dirty) in the table entry. A read walk never sets it, and the directory entry's bit 6 is never set by the walker.
- R9: An entry is written back only when a flag changes. The table entry write completes before the response.
- R10: After reset, `busy`, `rsp_valid` and `mem_req` are low. `busy` stays high from the accepting edge until the response cycle ends. Requests that arrive while busy are ignored.
- R11: `rsp_valid` is high for exactly one cycle per walk.
- R12: A memory request holds its address, its direction and its write data until it is acknowledged. A slower memory delays the walk but does not change its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Walk request, sampled while idle |
| req_vaddr | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user level |
| dir_frame | input | 20 | Frame number of the current page directory |
| busy | output | 1 | A walk is in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Physical address, zero on fault |
| rsp_fault | output | 2 | 0 none, 1 page not present, 2 protection |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Entry byte address |
| mem_wdata | output | 32 | Updated entry for write-back |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
With a memory that acknowledges on the edge after it sees a request, every memory transaction takes two cycles. `rsp_valid` therefore rises exactly 2×N edges after the accepting edge, where N is the number of reads and write-backs that the walk needs. Each added wait cycle in the memory adds one edge per transaction. The bench counts edges from acceptance, samples 1 ns after each edge, and compares the count with the value it derives from the entry flags. It checks the transaction log that the memory model keeps for the addresses, the write data and the ordering.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int BIT_P = 0;
  localparam int BIT_W = 1;
  localparam int BIT_U = 2;
  localparam int BIT_A = 5;
  localparam int BIT_D = 6;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_PAGE = 2'd1,
    FLT_PROT = 2'd2
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_DIR,
    ST_WR_DIR,
    ST_RD_TBL,
    ST_WR_TBL,
    ST_RESP
  } state_e;
endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
  parameter int AW    = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 10
) (
  input  logic [AW-OFF_W-1:0] frame,
  input  logic [IDX_W-1:0]    idx,
  output logic [AW-1:0]       addr
);
  localparam int ENT_B = OFF_W - IDX_W;

  assign addr = {frame, idx, {ENT_B{1'b0}}};
endmodule

// File: rtl/ptw_entry_chk.sv
module ptw_entry_chk
  import ptw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] entry,
  input  logic          is_write,
  input  logic          is_user,
  input  logic          leaf,
  output logic          present,
  output logic          allowed,
  output logic [AW-1:0] updated,
  output logic          changed
);
  always_comb begin
    present = entry[BIT_P];
    allowed = (!is_write || entry[BIT_W]) && (!is_user || entry[BIT_U]);
    updated = entry;
    updated[BIT_A] = 1'b1;
    if (leaf && is_write) updated[BIT_D] = 1'b1;
    changed = (updated != entry);
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int AW    = 32,
  parameter int OFF_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_vaddr,
  input  logic             req_write,
  input  logic             req_user,
  input  logic [AW-OFF_W-1:0] dir_frame,
  output logic             busy,
  output logic             rsp_valid,
  output logic [AW-1:0]    rsp_paddr,
  output logic [1:0]       rsp_fault,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [AW-1:0]    mem_wdata,
  input  logic             mem_ack,
  input  logic [AW-1:0]    mem_rdata
);
  localparam int FRM_W = AW - OFF_W;
  localparam int IDX_W = FRM_W / 2;

  state_e            state_q, state_d;
  fault_e            flt_q, flt_d;
  logic [AW-1:0]     va_q;
  logic              wr_q, usr_q;
  logic [FRM_W-1:0]  dbase_q, tbase_q, pframe_q;
  logic [AW-1:0]     wb_q;
  logic              ld_req, ld_dir, ld_tbl, ld_flt;

  logic [AW-1:0]     dir_ea, tbl_ea, ent_upd;
  logic              ent_present, ent_allowed, ent_changed, leaf;

  ptw_entry_addr #(.AW(AW), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_dir_ea (
    .frame(dbase_q), .idx(va_q[AW-1 -: IDX_W]), .addr(dir_ea)
  );

  ptw_entry_addr #(.AW(AW), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_tbl_ea (
    .frame(tbase_q), .idx(va_q[OFF_W +: IDX_W]), .addr(tbl_ea)
  );

  assign leaf = (state_q == ST_RD_TBL);

  ptw_entry_chk #(.AW(AW)) u_chk_ent (
    .entry(mem_rdata), .is_write(wr_q), .is_user(usr_q), .leaf(leaf),
    .present(ent_present), .allowed(ent_allowed),
    .updated(ent_upd), .changed(ent_changed)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    flt_d   = flt_q;
    ld_req  = 1'b0;
    ld_dir  = 1'b0;
    ld_tbl  = 1'b0;
    ld_flt  = 1'b0;
    case (state_q)
      ST_IDLE: if (req_valid) begin
        ld_req  = 1'b1;
        ld_flt  = 1'b1;
        flt_d   = FLT_NONE;
        state_d = ST_RD_DIR;
      end
      ST_RD_DIR, ST_RD_TBL: if (mem_ack) begin
        if (!ent_present) begin
          ld_flt  = 1'b1;
          flt_d   = FLT_PAGE;
          state_d = ST_RESP;
        end else if (!ent_allowed) begin
          ld_flt  = 1'b1;
          flt_d   = FLT_PROT;
          state_d = ST_RESP;
        end else if (state_q == ST_RD_DIR) begin
          ld_dir  = 1'b1;
          state_d = ent_changed ? ST_WR_DIR : ST_RD_TBL;
        end else begin
          ld_tbl  = 1'b1;
          state_d = ent_changed ? ST_WR_TBL : ST_RESP;
        end
      end
      ST_WR_DIR: if (mem_ack) state_d = ST_RD_TBL;
      ST_WR_TBL: if (mem_ack) state_d = ST_RESP;
      ST_RESP:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      flt_q    <= FLT_NONE;
      va_q     <= '0;
      wr_q     <= 1'b0;
      usr_q    <= 1'b0;
      dbase_q  <= '0;
      tbase_q  <= '0;
      pframe_q <= '0;
      wb_q     <= '0;
    end else begin
      state_q <= state_d;
      if (ld_flt) flt_q <= flt_d;
      if (ld_req) begin
        va_q    <= req_vaddr;
        wr_q    <= req_write;
        usr_q   <= req_user;
        dbase_q <= dir_frame;
      end
      if (ld_dir) tbase_q <= mem_rdata[AW-1:OFF_W];
      if (ld_tbl) pframe_q <= mem_rdata[AW-1:OFF_W];
      if (ld_dir || ld_tbl) wb_q <= ent_upd;
    end
  end

  // Outputs
  always_comb begin
    busy      = (state_q != ST_IDLE);
    mem_req   = (state_q == ST_RD_DIR) || (state_q == ST_WR_DIR) ||
                (state_q == ST_RD_TBL) || (state_q == ST_WR_TBL);
    mem_we    = (state_q == ST_WR_DIR) || (state_q == ST_WR_TBL);
    mem_addr  = ((state_q == ST_RD_DIR) || (state_q == ST_WR_DIR)) ? dir_ea : tbl_ea;
    mem_wdata = wb_q;
    rsp_valid = (state_q == ST_RESP);
    rsp_fault = flt_q;
    rsp_paddr = (flt_q == FLT_NONE) ? {pframe_q, va_q[OFF_W-1:0]} : '0;
  end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          busy,
  input logic          rsp_valid,
  input logic [1:0]    rsp_fault,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] mem_wdata
);
  assert_req_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  assert_mem_in_walk_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && req_valid |=> busy && !rsp_valid);

  assert_rsp_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && !busy);

  assert_wb_accessed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[5] && mem_wdata[0]);

  assert_fault_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_fault != 2'd3);
endmodule

bind ptw_walker ptw_walker_chk #(.AW(AW)) u_walker_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
  .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .mem_req(mem_req),
  .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/sim_ptw_walker.sv
`timescale 1ns/1ps
module sim_ptw_walker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_user;
  logic [31:0] req_vaddr;
  logic [19:0] dir_frame;
  logic        busy, rsp_valid;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_fault;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  ptw_walker u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user), .dir_frame(dir_frame),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // Memory model with transaction log
  logic [31:0] mem [logic [31:0]];
  logic [31:0] lg_addr [16];
  logic [31:0] lg_data [16];
  logic        lg_we   [16];
  int lg_n  = 0;
  int stall = 0;
  int wcnt  = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      wcnt = 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (wcnt < stall) wcnt++;
      else begin
        wcnt = 0;
        mem_ack <= 1'b1;
        if (lg_n < 16) begin
          lg_addr[lg_n] = mem_addr;
          lg_we[lg_n]   = mem_we;
          lg_data[lg_n] = mem_we ? mem_wdata : (mem.exists(mem_addr) ? mem[mem_addr] : 32'h0);
        end
        lg_n++;
        if (mem_we) mem[mem_addr] = mem_wdata;
        else mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
      end
    end
  end

  function automatic int n_writes();
    int n = 0;
    for (int i = 0; i < lg_n && i < 16; i++) if (lg_we[i]) n++;
    return n;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic walk(input logic [31:0] va, input bit wr, input bit usr,
                      output logic [1:0] flt, output logic [31:0] pa, output int cyc);
    bit held = 1'b1;
    @(negedge clk);
    lg_n = 0;
    req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = usr;
    @(posedge clk); #1;
    req_valid = 1'b0;
    cyc = 0;
    while (!rsp_valid && cyc < 200) begin
      if (!busy) held = 1'b0;
      @(posedge clk); #1;
      cyc++;
    end
    flt = rsp_fault;
    pa  = rsp_paddr;
    chk("R10 busy held during walk", {31'd0, held}, 32'd1);
    @(posedge clk); #1;
    chk("R11 single-cycle response", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R10 reset busy", {31'd0, busy}, 32'd0);
    chk("R10 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R10 reset mem_req", {31'd0, mem_req}, 32'd0);
  endtask

  task automatic t_hit();
    logic [1:0] f; logic [31:0] p; int c;
    walk(32'h00C0_5123, 1'b0, 1'b1, f, p, c);
    chk("R3 hit fault", {30'd0, f}, 32'd0);
    chk("R3 hit paddr", p, 32'h0ABC_D123);
    chk("R1 dir entry addr", lg_addr[0], 32'h0001_000C);
    chk("R2 table entry addr", lg_addr[1], 32'h0002_0014);
    chk("R9 no write when flags set", n_writes(), 0);
    chk("R11 hit latency", c, 4);
  endtask

  task automatic t_accessed();
    logic [1:0] f; logic [31:0] p; int c;
    walk(32'h01C0_9456, 1'b0, 1'b0, f, p, c);
    chk("R3 paddr", p, 32'h0055_5456);
    chk("R7 dir write addr", lg_addr[1], 32'h0001_001C);
    chk("R7 dir write data", lg_data[1], 32'h0003_0023);
    chk("R8 read sets no dirty", lg_data[3], 32'h0055_5023);
    chk("R9 table write before response", lg_n, 4);
    chk("R11 latency two write-backs", c, 8);
  endtask

  task automatic t_dirty();
    logic [1:0] f; logic [31:0] p; int c;
    walk(32'h01C0_9456, 1'b1, 1'b0, f, p, c);
    chk("R8 dirty write data", lg_data[2], 32'h0055_5063);
    chk("R9 only table written", n_writes(), 1);
    chk("R8 dir dirty untouched", mem[32'h0001_001C], 32'h0003_0023);
    chk("R11 latency one write-back", c, 6);
    walk(32'h01C0_9456, 1'b1, 1'b0, f, p, c);
    chk("R9 no write when unchanged", n_writes(), 0);
    chk("R3 repeat paddr", p, 32'h0055_5456);
  endtask

  task automatic t_dir_absent();
    logic [1:0] f; logic [31:0] p; int c;
    walk(32'hFFC0_1000, 1'b0, 1'b0, f, p, c);
    chk("R4 page fault code", {30'd0, f}, 32'd1);
    chk("R4 paddr zero", p, 32'h0);
    chk("R4 single read", lg_n, 1);
    chk("R1 top dir index addr", lg_addr[0], 32'h0001_0FFC);
    chk("R4 latency", c, 2);
  endtask

  task automatic t_tbl_absent();
    logic [1:0] f; logic [31:0] p; int c;
    walk(32'h0100_0ABC, 1'b1, 1'b0, f, p, c);
    chk("R5 page fault code", {30'd0, f}, 32'd1);
    chk("R5 no writes", n_writes(), 0);
    chk("R5 entry unchanged", mem[32'h0005_0000], 32'h0000_1066);
  endtask

  task automatic t_prot();
    logic [1:0] f; logic [31:0] p; int c;
    walk(32'h0140_2010, 1'b0, 1'b1, f, p, c);
    chk("R6 user denied code", {30'd0, f}, 32'd2);
    chk("R6 denied entry not written", mem[32'h0006_0008], 32'h0077_7003);
    chk("R6 user denied latency", c, 4);
    walk(32'h0140_2010, 1'b0, 1'b0, f, p, c);
    chk("R6 supervisor allowed", {30'd0, f}, 32'd0);
    chk("R7 accessed set later", mem[32'h0006_0008], 32'h0077_7023);
    walk(32'h0180_0000, 1'b1, 1'b0, f, p, c);
    chk("R6 dir write denied code", {30'd0, f}, 32'd2);
    chk("R6 no table read", lg_n, 1);
    chk("R6 dir denied latency", c, 2);
  endtask

  task automatic t_busy_ignore();
    int c = 0;
    bit extra = 1'b0;
    @(negedge clk);
    lg_n = 0;
    req_valid = 1'b1; req_vaddr = 32'h00C0_5123; req_write = 1'b0; req_user = 1'b0;
    @(posedge clk); #1;
    req_vaddr = 32'hFFC0_1000;
    @(posedge clk); #1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    c = 3;
    while (!rsp_valid && c < 200) begin @(posedge clk); #1; c++; end
    chk("R10 first request served", rsp_paddr, 32'h0ABC_D123);
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1;
      if (rsp_valid || mem_req || busy) extra = 1'b1;
    end
    chk("R10 busy request ignored", {31'd0, extra}, 32'd0);
  endtask

  task automatic t_stall();
    logic [1:0] f; logic [31:0] p; int c;
    stall = 2;
    walk(32'h00C0_5123, 1'b0, 1'b1, f, p, c);
    stall = 0;
    chk("R12 slow memory paddr", p, 32'h0ABC_D123);
    chk("R12 slow memory latency", c, 8);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0; req_user = 1'b0;
    dir_frame = 20'h00010;
    mem[32'h0001_000C] = 32'h0002_0027;
    mem[32'h0002_0014] = 32'h0ABC_D067;
    mem[32'h0001_001C] = 32'h0003_0003;
    mem[32'h0003_0024] = 32'h0055_5003;
    mem[32'h0001_0FFC] = 32'h0004_0006;
    mem[32'h0001_0010] = 32'h0005_0027;
    mem[32'h0005_0000] = 32'h0000_1066;
    mem[32'h0001_0014] = 32'h0006_0027;
    mem[32'h0006_0008] = 32'h0077_7003;
    mem[32'h0001_0018] = 32'h0007_0025;
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_hit();
    t_accessed();
    t_dirty();
    t_dir_absent();
    t_tbl_absent();
    t_prot();
    t_busy_ignore();
    t_stall();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule